// File: doc/BRIEF.md
# Four-Channel Compare Alarm Controller

The block holds four independent one-shot alarms against a free-running microsecond timebase that lives outside it. Each alarm keeps a 32-bit target; software writes the target, which arms the alarm, and when the low 32 bits of the timebase equal the target, the alarm fires. Firing disarms the alarm and latches a raw interrupt bit for that channel.

A small interrupt stage combines the raw bits with per-channel enable and force bits. Each channel gets its own interrupt output. Software clears raw bits by writing ones to them. It can cancel pending alarms by writing ones to the armed register. All access goes through a plain word-addressed register port with a single-cycle write strobe and a combinational read.

Register words: 0 to 3 hold the targets of channels 0 to 3, 4 is armed, 5 is raw, 6 is enable, 7 is force and 8 is status. In the four mask registers, bit n belongs to channel n. Any other word reads as zero.

Top module: `alarm_ctrl`

## Requirements
- R1: After reset, the armed, raw, enable and force registers read zero, and every bit of irq_o is low.
- R2: A write to target word n (0..3) stores the value, which reads back from that word. It sets bit n of armed (word 4) in the next cycle.
- R3: An armed channel whose target equals time_lo_i fires on that clock edge. Its armed bit reads 0 and its raw bit (word 5) reads 1 afterwards. An unarmed channel never sets its raw bit on a match.
- R4: Writing ones to armed (word 4) clears those armed bits at once. The other armed bits are left alone. A cancelled channel does not fire when its target later matches.
- R5: A target write in the same cycle as a match of that channel's old target wins. The channel stays armed with the new target, and raw is not set.
- R6: Writing ones to raw (word 5) clears those bits. Zero bits in the write data leave raw bits unchanged.
- R7: When a channel fires in the same cycle as a write that clears its raw bit, the raw bit ends up set.
- R8: Enable (word 6) and force (word 7) read back as written. For each n, status bit n (word 8) and irq_o[n] equal (raw[n] AND enable[n]) OR force[n].
- R9: Writes to status (word 8) have no effect. Each channel's arm, fire and clear leave the other channels' state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| time_lo_i | input | 32 | Low word of the microsecond timebase |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 4 | Per-channel masked interrupt |

## Verification
A stuck or wrong armed flag shows up within one cycle of a matching time value. A raw bit that wrongly appears or goes missing is visible in the raw read at once, and on irq_o as soon as enable is set. Clear errors and collision errors are caught on the cycle right after the collision, by reading armed and raw back. Cross-channel leakage is caught by reading every channel's bits after each single-channel action.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int unsigned NCH      = 4;
  localparam int unsigned TW       = 32;
  localparam int unsigned AW       = 4;
  localparam int unsigned A_ARMED  = 4;
  localparam int unsigned A_RAW    = 5;
  localparam int unsigned A_EN     = 6;
  localparam int unsigned A_FRC    = 7;
  localparam int unsigned A_STATUS = 8;
endpackage

// File: rtl/alarm_channel.sv
module alarm_channel #(
  parameter int unsigned TW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [TW-1:0] wdata_i,
  input  logic          cancel_i,
  input  logic [TW-1:0] time_i,
  output logic [TW-1:0] target_o,
  output logic          armed_o,
  output logic          fire_o
);
  logic [TW-1:0] target_q;
  logic          armed_q;

  // a target write in the same cycle overrides both a match and a cancel
  assign fire_o = armed_q && (target_q == time_i) && !wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      target_q <= '0;
      armed_q  <= 1'b0;
    end else begin
      if (wr_i) target_q <= wdata_i;
      if (wr_i)                     armed_q <= 1'b1;
      else if (cancel_i || fire_o)  armed_q <= 1'b0;
    end
  end

  assign target_o = target_q;
  assign armed_o  = armed_q;

  a_r2_write_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> armed_q);
  a_r3_fire_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !armed_q);
  a_r4_cancel_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cancel_i && !wr_i) |=> !armed_q);
endmodule

// File: rtl/alarm_irq.sv
module alarm_irq #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  input  logic           en_we_i,
  input  logic           frc_we_i,
  input  logic [NCH-1:0] wdata_i,
  output logic [NCH-1:0] raw_o,
  output logic [NCH-1:0] en_o,
  output logic [NCH-1:0] frc_o,
  output logic [NCH-1:0] irq_o
);
  logic [NCH-1:0] raw_q, en_q, frc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= '0;
      en_q  <= '0;
      frc_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_i) | set_i;  // set beats clear
      if (en_we_i)  en_q  <= wdata_i;
      if (frc_we_i) frc_q <= wdata_i;
    end
  end

  assign raw_o = raw_q;
  assign en_o  = en_q;
  assign frc_o = frc_q;
  assign irq_o = (raw_q & en_q) | frc_q;

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((raw_q & $past(set_i)) == $past(set_i)));
  a_r6_clear_works: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((raw_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
#(
  parameter int unsigned N  = NCH,
  parameter int unsigned W  = TW,
  parameter int unsigned AD = AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  time_lo_i,
  input  logic          we_i,
  input  logic [AD-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic [N-1:0]  irq_o
);
  logic [N-1:0]  armed, fire, tgt_we, raw, en, frc;
  logic [W-1:0]  target [N];
  logic          wr_armed, wr_raw, wr_en, wr_frc;

  assign wr_armed = we_i && (addr_i == AD'(A_ARMED));
  assign wr_raw   = we_i && (addr_i == AD'(A_RAW));
  assign wr_en    = we_i && (addr_i == AD'(A_EN));
  assign wr_frc   = we_i && (addr_i == AD'(A_FRC));

  for (genvar i = 0; i < N; i++) begin : g_ch
    assign tgt_we[i] = we_i && (addr_i == AD'(i));
    alarm_channel #(.TW(W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (tgt_we[i]),
      .wdata_i  (wdata_i),
      .cancel_i (wr_armed && wdata_i[i]),
      .time_i   (time_lo_i),
      .target_o (target[i]),
      .armed_o  (armed[i]),
      .fire_o   (fire[i])
    );
  end

  alarm_irq #(.NCH(N)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (fire),
    .clr_i    (wr_raw ? wdata_i[N-1:0] : '0),
    .en_we_i  (wr_en),
    .frc_we_i (wr_frc),
    .wdata_i  (wdata_i[N-1:0]),
    .raw_o    (raw),
    .en_o     (en),
    .frc_o    (frc),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i < AD'(N)) rdata_o = target[addr_i[$clog2(N)-1:0]];
    else if (addr_i == AD'(A_ARMED))  rdata_o[N-1:0] = armed;
    else if (addr_i == AD'(A_RAW))    rdata_o[N-1:0] = raw;
    else if (addr_i == AD'(A_EN))     rdata_o[N-1:0] = en;
    else if (addr_i == AD'(A_FRC))    rdata_o[N-1:0] = frc;
    else if (addr_i == AD'(A_STATUS)) rdata_o[N-1:0] = irq_o;
  end

  a_r3_only_armed_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fire & ~armed) == '0));
  a_r9_fire_one_hot_per_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fire & tgt_we) == '0));
endmodule

// File: tb/alarm_ctrl_bench.sv
module alarm_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] time_lo = 0;
  logic        we = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  alarm_ctrl u_alarm_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .time_lo_i(time_lo), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // called at negedge; returns at the following negedge
  task automatic wr(logic [3:0] a, logic [31:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic t_reset();
    rd_chk("R1 armed", 4, 0);
    rd_chk("R1 raw", 5, 0);
    rd_chk("R1 enable", 6, 0);
    rd_chk("R1 force", 7, 0);
    chk("R1 irq", {28'd0, irq}, 0);
  endtask

  task automatic t_arm_fire();
    time_lo = 100;
    wr(0, 105);
    rd_chk("R2 target0", 0, 105);
    rd_chk("R2 armed", 4, 32'h1);
    time_lo = 105; tick();
    rd_chk("R3 disarmed", 4, 0);
    rd_chk("R3 raw set", 5, 32'h1);
    // unarmed channel 1 target is 0: matching time 0 must not fire it
    time_lo = 0; tick();
    rd_chk("R3 unarmed no fire", 5, 32'h1);
  endtask

  task automatic t_cancel();
    time_lo = 10;
    wr(3, 800);
    wr(1, 900);
    rd_chk("R2 armed 1 and 3", 4, 32'ha);
    wr(4, 32'h8);
    rd_chk("R4 cancel only ch3", 4, 32'h2);
    time_lo = 800; tick();
    rd_chk("R4 cancelled no fire", 5, 32'h1);
    wr(4, 32'h2);
    rd_chk("R4 cancel ch1", 4, 0);
  endtask

  task automatic t_write_vs_match();
    time_lo = 0;
    wr(2, 600);
    time_lo = 600;
    wr(2, 700);
    rd_chk("R5 still armed", 4, 32'h4);
    rd_chk("R5 no raw", 5, 32'h1);
    rd_chk("R5 new target", 2, 700);
    time_lo = 700; tick();
    rd_chk("R5 fires on new target", 5, 32'h5);
    rd_chk("R9 ch2 fire leaves others", 4, 0);
  endtask

  task automatic t_clear();
    wr(5, 32'h4);
    rd_chk("R6 clear bit2 only", 5, 32'h1);
    wr(5, 32'h0);
    rd_chk("R6 zero write no effect", 5, 32'h1);
    time_lo = 0;
    wr(1, 300);
    time_lo = 300;
    wr(5, 32'h3);
    rd_chk("R7 set beats clear", 5, 32'h2);
    wr(5, 32'h2);
    rd_chk("R6 clear bit1", 5, 32'h0);
  endtask

  task automatic t_irq();
    time_lo = 0;
    wr(0, 50);
    time_lo = 50; tick();
    chk("R8 irq masked", {28'd0, irq}, 0);
    wr(6, 32'h1);
    rd_chk("R8 enable readback", 6, 32'h1);
    chk("R8 irq enabled", {28'd0, irq}, 32'h1);
    wr(7, 32'h4);
    rd_chk("R8 force readback", 7, 32'h4);
    chk("R8 irq forced", {28'd0, irq}, 32'h5);
    rd_chk("R8 status", 8, 32'h5);
    wr(8, 32'hf);
    rd_chk("R9 status write ignored", 8, 32'h5);
    rd_chk("R9 raw untouched", 5, 32'h1);
    wr(6, 32'h0);
    chk("R8 enable off", {28'd0, irq}, 32'h4);
    wr(7, 32'h0);
    chk("R8 force off", {28'd0, irq}, 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_arm_fire();
    t_cancel();
    t_write_vs_match();
    t_clear();
    t_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule